// File: doc/BRIEF.md
# System Bus Access Engine

This block gives an external debug port a path into system memory. Software on the debug side sees a small set of 32-bit registers: one control/status word, up to four address words and four data words. Memory transfers are never issued by a separate command. They happen as side effects of register accesses: a write to the lowest data word, a write to the lowest address word, or a read of the lowest data word. The engine then runs one transfer on a generic memory bus that has a request, an acknowledge and an error signal.

Every transfer is checked for size and alignment before it is issued. Any failure is kept in a sticky error field. The error field, and a sticky flag that records a register access made while a transfer was still running, both cleared by writing ones, hold off every later transfer until software clears them. An optional post-increment steps the address by the transfer width after each completed access.

Register offsets on `reg_addr`: 0x0 is the control/status word, 0x4 to 0x7 are address words 0 to 3 (only `ADDR_W/32` of them exist), and 0x8 to 0xB are data words 0 to 3.

Top module: `sysbus_access_engine`

## Requirements
- R1: After reset, the control/status word reads as version 1 in bits [19:16] and the `SIZE_SUPPORT` flags in bits [15:11] (bit 11+n set when size n is allowed; default 5'b01111). Every other bit reads 0, `bus_req` is low and all address and data words read 0.
- R2: When no error is pending, a write to data word 0 issues one bus write. It uses the current address, the size field (bits [7:5], width 2^size bytes) and all data words. Writes to the other data words, and to address words when read-on-address is off, only store the value and leave `bus_req` low.
- R3: With read-on-address set (bit 9), a write to address word 0 issues a bus read at the new address. The returned data is stored masked to 2^size bytes, and the data words above that width are cleared.
- R4: With read-on-data set (bit 10), a read of data word 0 returns the stored value and then issues the next bus read.
- R5: With autoincrement set (bit 8), the address grows by 2^size after each acknowledged access, and the new value reads back from the address words.
- R6: A bus error sets the error field (bits [2:0]) to 2 and leaves the address unchanged.
- R7: An access whose address is not a multiple of 2^size sets the error field to 3 and never raises `bus_req`.
- R8: An access with a size whose support flag is clear, or a size above 4, sets the error field to 4 and never raises `bus_req`.
- R9: Writing the control/status word clears each error-field bit that is written as 1. The field keeps its value otherwise.
- R10: The busy flag (bit 4) and `bus_req` are high from the cycle after launch until the cycle the bus answers. Address, size and direction stay stable during that time.
- R11: A write to an address or data word, or a read of data word 0, made while busy sets the busy-error flag (bit 3) and is dropped. Writing 1 to bit 3 clears the flag.
- R12: While the error field is nonzero or the busy-error flag is set, none of the triggers issues a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register offset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| bus_req | output | 1 | Transfer request, held until answered |
| bus_we | output | 1 | Transfer direction, 1 = write |
| bus_size | output | 3 | Transfer width as log2 of bytes |
| bus_addr | output | ADDR_W | Transfer byte address |
| bus_wdata | output | 128 | Write data, byte 0 in bits [7:0] |
| bus_rdata | input | 128 | Read data |
| bus_ack | input | 1 | Transfer completed |
| bus_err | input | 1 | Transfer failed |

## Verification
The bus response and a software touch of the data or address registers can land in the same cycle. The rule here is that busy is judged on its registered value, so the touch still counts as a busy error and is dropped, while the completing access finishes normally. The bench provokes this by holding a write to data word 1 until it sees `bus_ack` asserted. It then checks that the busy-error flag is set, that data word 1 is unchanged, and that memory holds the completed write. A behavioural model in the bench tracks busy, direction and address on every clock, and each cycle is compared against `bus_req`, `bus_we` and `bus_addr`.

// File: rtl/sbx_pkg.sv
package sbx_pkg;

    localparam int unsigned WORD_W     = 32;
    localparam int unsigned DATA_WORDS = 4;
    localparam int unsigned DATA_W     = WORD_W * DATA_WORDS;
    localparam logic [3:0]  VERSION    = 4'd1;

    typedef enum logic [2:0] {
        ERR_NONE  = 3'd0,
        ERR_BUS   = 3'd2,
        ERR_ALIGN = 3'd3,
        ERR_SIZE  = 3'd4
    } err_e;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_ADDR = 2'd1,
        SEL_DATA = 2'd2,
        SEL_NONE = 2'd3
    } sel_e;

    // configuration bits of the control word, bits [10:5]
    typedef struct packed {
        logic       rd_on_data;
        logic       rd_on_addr;
        logic       auto_inc;
        logic [2:0] size;
    } cfg_t;

    function automatic sel_e decode_sel(input logic [3:0] a);
        case (a[3:2])
            2'd0:    return (a[1:0] == 2'd0) ? SEL_CTRL : SEL_NONE;
            2'd1:    return SEL_ADDR;
            2'd2:    return SEL_DATA;
            default: return SEL_NONE;
        endcase
    endfunction

    // byte-lane mask for a transfer of 2^s bytes
    function automatic logic [DATA_W-1:0] lane_mask(input logic [2:0] s);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < int'(DATA_W / 8); i++) begin
            if (i < (1 << s)) m[i*8 +: 8] = 8'hFF;
        end
        return m;
    endfunction

endpackage

// File: rtl/sbx_size_check.sv
module sbx_size_check
    import sbx_pkg::*;
#(
    parameter logic [4:0] SUPPORT = 5'b01111
) (
    input  logic [2:0] size,
    input  logic [3:0] addr_lo,
    output err_e       verdict
);
    localparam logic [7:0] SUP_EXT = {3'b000, SUPPORT};

    logic       supported;
    logic [4:0] span;
    logic [3:0] align_mask;

    always_comb begin
        supported  = SUP_EXT[size];
        span       = 5'd1 << size;
        align_mask = 4'(span - 5'd1);
        if (!supported)
            verdict = ERR_SIZE;
        else if ((addr_lo & align_mask) != 4'd0)
            verdict = ERR_ALIGN;
        else
            verdict = ERR_NONE;
    end
endmodule

// File: rtl/sbx_bus_seq.sv
module sbx_bus_seq (
    input  logic       clk,
    input  logic       rst,
    input  logic       launch,
    input  logic       launch_we,
    input  logic [2:0] launch_size,
    input  logic       bus_ack,
    input  logic       bus_err,
    output logic       busy,
    output logic       op_we,
    output logic [2:0] op_size,
    output logic       done_ok,
    output logic       done_fail
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            op_we   <= 1'b0;
            op_size <= 3'd0;
        end else if (!busy) begin
            if (launch) begin
                busy    <= 1'b1;
                op_we   <= launch_we;
                op_size <= launch_size;
            end
        end else if (bus_ack || bus_err) begin
            busy <= 1'b0;
        end
    end

    assign done_fail = busy && bus_err;
    assign done_ok   = busy && bus_ack && !bus_err;
endmodule

// File: rtl/sysbus_access_engine.sv
module sysbus_access_engine
    import sbx_pkg::*;
#(
    parameter int unsigned ADDR_W       = 64,
    parameter logic [4:0]  SIZE_SUPPORT = 5'b01111
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        reg_addr,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [2:0]        bus_size,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ack,
    input  logic              bus_err
);
    localparam int unsigned ADDR_WORDS = ADDR_W / WORD_W;

    cfg_t              cfg_q;
    logic [2:0]        err_q;
    logic              berr_q;
    logic [ADDR_W-1:0] addr_q, addr_wr;
    logic [DATA_W-1:0] data_q, data_wr;

    sel_e       sel;
    logic [1:0] idx;
    logic       wr_ctrl, hit_addr, hit_data, rd_d0, touch;
    logic       want_wr, want_rd, blocked, request, launch;
    err_e       verdict;

    logic       busy, op_we, done_ok, done_fail;
    logic [2:0] op_size;

    always_comb begin
        sel      = decode_sel(reg_addr);
        idx      = reg_addr[1:0];
        wr_ctrl  = reg_we && (sel == SEL_CTRL);
        hit_addr = reg_we && (sel == SEL_ADDR) && (32'(idx) < ADDR_WORDS);
        hit_data = reg_we && (sel == SEL_DATA);
        rd_d0    = reg_re && !reg_we && (sel == SEL_DATA) && (idx == 2'd0);
        touch    = busy && (hit_addr || hit_data || rd_d0);
    end

    // register values as they stand after this cycle's write
    always_comb begin
        addr_wr = addr_q;
        for (int w = 0; w < int'(ADDR_WORDS); w++) begin
            if (hit_addr && int'(idx) == w) addr_wr[w*WORD_W +: WORD_W] = reg_wdata;
        end
        data_wr = data_q;
        for (int w = 0; w < int'(DATA_WORDS); w++) begin
            if (hit_data && int'(idx) == w) data_wr[w*WORD_W +: WORD_W] = reg_wdata;
        end
    end

    always_comb begin
        want_wr = hit_data && (idx == 2'd0);
        want_rd = (hit_addr && (idx == 2'd0) && cfg_q.rd_on_addr)
               || (rd_d0 && cfg_q.rd_on_data);
        blocked = busy || berr_q || (err_q != ERR_NONE);
        request = (want_wr || want_rd) && !blocked;
        launch  = request && (verdict == ERR_NONE);
    end

    sbx_size_check #(.SUPPORT(SIZE_SUPPORT)) check_i (
        .size    (cfg_q.size),
        .addr_lo (addr_wr[3:0]),
        .verdict (verdict)
    );

    sbx_bus_seq seq_i (
        .clk         (clk),
        .rst         (rst),
        .launch      (launch),
        .launch_we   (want_wr),
        .launch_size (cfg_q.size),
        .bus_ack     (bus_ack),
        .bus_err     (bus_err),
        .busy        (busy),
        .op_we       (op_we),
        .op_size     (op_size),
        .done_ok     (done_ok),
        .done_fail   (done_fail)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            err_q  <= ERR_NONE;
            berr_q <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            if (wr_ctrl) begin
                cfg_q  <= cfg_t'(reg_wdata[10:5]);
                err_q  <= err_q & ~reg_wdata[2:0];
                berr_q <= berr_q & ~reg_wdata[3];
            end
            if (!busy) begin
                addr_q <= addr_wr;
                data_q <= data_wr;
            end
            if (touch) berr_q <= 1'b1;
            if (request && verdict != ERR_NONE) err_q <= verdict;
            if (done_fail) err_q <= ERR_BUS;
            if (done_ok) begin
                if (!op_we) data_q <= bus_rdata & lane_mask(op_size);
                if (cfg_q.auto_inc) addr_q <= addr_q + (ADDR_W'(1) << op_size);
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_CTRL: reg_rdata = {12'd0, VERSION, SIZE_SUPPORT, cfg_q, busy, berr_q, err_q};
            SEL_ADDR: begin
                for (int w = 0; w < int'(ADDR_WORDS); w++) begin
                    if (int'(idx) == w) reg_rdata = addr_q[w*WORD_W +: WORD_W];
                end
            end
            SEL_DATA: begin
                for (int w = 0; w < int'(DATA_WORDS); w++) begin
                    if (int'(idx) == w) reg_rdata = data_q[w*WORD_W +: WORD_W];
                end
            end
            default: reg_rdata = '0;
        endcase
    end

    assign bus_req   = busy;
    assign bus_we    = op_we;
    assign bus_size  = op_size;
    assign bus_addr  = addr_q;
    assign bus_wdata = data_q;
endmodule

// File: rtl/sbx_checker.sv
module sbx_checker #(
    parameter int unsigned ADDR_W       = 64,
    parameter logic [4:0]  SIZE_SUPPORT = 5'b01111
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_req,
    input logic              bus_we,
    input logic              bus_ack,
    input logic              bus_err,
    input logic [2:0]        bus_size,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [2:0]        err_q,
    input logic              berr_q,
    input logic [3:0]        reg_addr,
    input logic              reg_we,
    input logic [31:0]       reg_wdata
);
    localparam logic [7:0] SUP_EXT = {3'b000, SIZE_SUPPORT};

    logic [4:0] span;
    logic [3:0] amask;
    logic       ctrl_wr;
    assign span    = 5'd1 << bus_size;
    assign amask   = 4'(span - 5'd1);
    assign ctrl_wr = reg_we && (reg_addr == 4'h0);

    a_r10_req_held: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_ack && !bus_err |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_size));

    a_r10_req_drops: assert property (@(posedge clk) disable iff (rst)
        bus_req && (bus_ack || bus_err) |=> !bus_req);

    a_r6_bus_err_code: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_err |=> err_q == 3'd2);

    a_r7_aligned_only: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> (bus_addr[3:0] & amask) == 4'd0);

    a_r8_supported_only: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> SUP_EXT[bus_size]);

    a_r12_blocked: assert property (@(posedge clk) disable iff (rst)
        (err_q != 3'd0 || berr_q) && !bus_req |=> !bus_req);

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_q != 3'd0 && !ctrl_wr |=> $stable(err_q));

    a_r11_berr_sticky: assert property (@(posedge clk) disable iff (rst)
        berr_q && !(ctrl_wr && reg_wdata[3]) |=> berr_q);
endmodule

bind sysbus_access_engine sbx_checker #(.ADDR_W(ADDR_W), .SIZE_SUPPORT(SIZE_SUPPORT)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_ack   (bus_ack),
    .bus_err   (bus_err),
    .bus_size  (bus_size),
    .bus_addr  (bus_addr),
    .err_q     (err_q),
    .berr_q    (berr_q),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata)
);

// File: tb/sysbus_access_engine_tb_top.sv
module sysbus_access_engine_tb_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [3:0]   reg_addr = 4'h0;
    logic         reg_we = 1'b0;
    logic         reg_re = 1'b0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         bus_req, bus_we;
    logic [2:0]   bus_size;
    logic [63:0]  bus_addr;
    logic [127:0] bus_wdata;
    logic [127:0] bus_rdata = '0;
    logic         bus_ack = 1'b0;
    logic         bus_err = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int lat = 0;
    int wcnt = 0;
    logic [7:0] mem [0:255];

    always #5 clk = ~clk;

    sysbus_access_engine dut_i (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we), .reg_re(reg_re),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req), .bus_we(bus_we),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .bus_err(bus_err)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // memory responder: legal space is bytes 0..255
    always @(negedge clk) begin
        bus_ack = 1'b0;
        bus_err = 1'b0;
        if (bus_req) begin
            if (wcnt >= lat) begin
                wcnt = 0;
                if (bus_addr[63:8] != 56'd0) bus_err = 1'b1;
                else begin
                    bus_ack = 1'b1;
                    bus_rdata = '0;
                    for (int i = 0; i < (1 << bus_size); i++) begin
                        if (bus_we) mem[8'(bus_addr[7:0] + 8'(i))] = bus_wdata[i*8 +: 8];
                        else bus_rdata[i*8 +: 8] = mem[8'(bus_addr[7:0] + 8'(i))];
                    end
                end
            end else wcnt++;
        end else wcnt = 0;
    end

    // behavioural reference model
    logic         m_busy, m_we, m_berr, m_ai, m_roa, m_rod;
    logic [2:0]   m_err, m_size, m_opsz;
    logic [63:0]  m_addr;
    logic [127:0] m_data;

    always @(posedge clk) begin
        logic [63:0]  na;
        logic [127:0] nd;
        logic [127:0] mk;
        logic         st;
        if (rst) begin
            m_busy <= 0; m_we <= 0; m_berr <= 0; m_ai <= 0; m_roa <= 0; m_rod <= 0;
            m_err <= 0; m_size <= 0; m_opsz <= 0; m_addr <= 0; m_data <= 0;
        end else begin
            na = m_addr;
            nd = m_data;
            if (reg_we && reg_addr == 4'h4) na[31:0] = reg_wdata;
            if (reg_we && reg_addr == 4'h5) na[63:32] = reg_wdata;
            for (int k = 0; k < 4; k++)
                if (reg_we && reg_addr == 4'(8 + k)) nd[k*32 +: 32] = reg_wdata;
            if (reg_we && reg_addr == 4'h0) begin
                m_size <= reg_wdata[7:5]; m_ai <= reg_wdata[8];
                m_roa <= reg_wdata[9]; m_rod <= reg_wdata[10];
                m_err <= m_err & ~reg_wdata[2:0];
                m_berr <= m_berr & ~reg_wdata[3];
            end
            if (!m_busy) begin
                m_addr <= na;
                m_data <= nd;
            end else if ((reg_we && (reg_addr == 4'h4 || reg_addr == 4'h5 || reg_addr[3:2] == 2'b10))
                      || (reg_re && !reg_we && reg_addr == 4'h8)) m_berr <= 1;
            st = !m_busy && m_err == 0 && !m_berr &&
                 ((reg_we && reg_addr == 4'h8) || (reg_we && reg_addr == 4'h4 && m_roa) ||
                  (reg_re && !reg_we && reg_addr == 4'h8 && m_rod));
            if (st) begin
                if (m_size > 3) m_err <= 4;
                else if ((na % (64'd1 << m_size)) != 0) m_err <= 3;
                else begin
                    m_busy <= 1; m_we <= (reg_we && reg_addr == 4'h8); m_opsz <= m_size;
                end
            end
            if (m_busy && (bus_ack || bus_err)) begin
                m_busy <= 0;
                if (bus_err) m_err <= 2;
                else begin
                    mk = (m_opsz >= 4) ? '1 : ((128'd1 << (8 << m_opsz)) - 128'd1);
                    if (!m_we) m_data <= bus_rdata & mk;
                    if (m_ai) m_addr <= m_addr + (64'd1 << m_opsz);
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk("R10 model busy", {127'd0, bus_req}, {127'd0, m_busy});
            if (m_busy) begin
                chk("R2 model addr", {64'd0, bus_addr}, {64'd0, m_addr});
                chk("R2 model dir", {127'd0, bus_we}, {127'd0, m_we});
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        reg_addr = a; reg_re = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (bus_req && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(4'h0, v); chk("R1 ctrl", 128'(v), 128'h17800);
        chk("R1 req", {127'd0, bus_req}, 128'd0);
        rd(4'h4, v); chk("R1 addr0", 128'(v), 128'd0);

        // R2 write, latch of upper words
        wr(4'h0, 32'h40);
        wr(4'h4, 32'h10);
        wr(4'h9, 32'hAAAA);
        chk("R2 no req on data1", {127'd0, bus_req}, 128'd0);
        wr(4'h8, 32'h12345678);
        wait_idle();
        chk("R2 mem", 128'({mem[8'h13], mem[8'h12], mem[8'h11], mem[8'h10]}), 128'h12345678);

        // R3 read on address, 32-bit and 8-bit
        wr(4'h0, 32'h240);
        wr(4'h4, 32'h10);
        wait_idle();
        rd(4'h8, v); chk("R3 data0", 128'(v), 128'h12345678);
        rd(4'h9, v); chk("R3 data1 cleared", 128'(v), 128'd0);
        wr(4'h0, 32'h200);
        wr(4'h4, 32'h11);
        wait_idle();
        rd(4'h8, v); chk("R3 byte read", 128'(v), 128'h56);

        // R5 autoincrement, 32 and 64 bit
        wr(4'h0, 32'h140);
        wr(4'h4, 32'h20);
        for (int i = 1; i <= 3; i++) begin
            wr(4'h8, 32'(i));
            wait_idle();
        end
        rd(4'h4, v); chk("R5 addr after 3", 128'(v), 128'h2C);
        chk("R5 mem 0x28", 128'(mem[8'h28]), 128'h03);
        wr(4'h0, 32'h160);
        wr(4'h4, 32'h40);
        wr(4'h9, 32'hCAFE);
        wr(4'h8, 32'hBEEF);
        wait_idle();
        rd(4'h4, v); chk("R5 addr 64-bit step", 128'(v), 128'h48);
        chk("R5 mem hi word", 128'(mem[8'h44]), 128'hFE);

        // R4 read on data
        wr(4'h0, 32'h540);
        wr(4'h4, 32'h20);
        chk("R2 no req on addr0", {127'd0, bus_req}, 128'd0);
        rd(4'h8, v);
        wait_idle();
        rd(4'h8, v); chk("R4 first", 128'(v), 128'h1);
        wait_idle();
        rd(4'h8, v); chk("R4 second", 128'(v), 128'h2);
        wait_idle();
        rd(4'h4, v); chk("R4 addr", 128'(v), 128'h2C);

        // R7 misaligned, R12 blocked, R9 partial clear
        wr(4'h0, 32'h20);
        wr(4'h4, 32'h31);
        wr(4'h8, 32'h0);
        chk("R7 no req", {127'd0, bus_req}, 128'd0);
        rd(4'h0, v); chk("R7 code", 128'(v), 128'h17823);
        wr(4'h4, 32'h30);
        wr(4'h8, 32'h0);
        chk("R12 blocked by err", {127'd0, bus_req}, 128'd0);
        wr(4'h0, 32'h21);
        rd(4'h0, v); chk("R9 partial clear", 128'(v), 128'h17822);
        wr(4'h0, 32'h22);
        rd(4'h0, v); chk("R9 full clear", 128'(v), 128'h17820);

        // R8 unsupported size
        wr(4'h0, 32'h80);
        wr(4'h4, 32'h0);
        wr(4'h8, 32'h0);
        chk("R8 no req", {127'd0, bus_req}, 128'd0);
        rd(4'h0, v); chk("R8 code", 128'(v), 128'h17884);
        wr(4'h0, 32'h84);

        // R6 bus error
        wr(4'h0, 32'h140);
        wr(4'h5, 32'h1);
        wr(4'h4, 32'h0);
        wr(4'h8, 32'h5);
        wait_idle();
        rd(4'h0, v); chk("R6 code", 128'(v), 128'h17942);
        rd(4'h4, v); chk("R6 addr0 held", 128'(v), 128'd0);
        rd(4'h5, v); chk("R6 addr1 held", 128'(v), 128'h1);
        wr(4'h0, 32'h142);
        wr(4'h5, 32'h0);

        // R10 / R11 busy and busy error
        lat = 3;
        wr(4'h0, 32'h40);
        wr(4'h4, 32'h50);
        wr(4'h8, 32'h77);
        rd(4'h0, v); chk("R10 busy bit", 128'(v), 128'h17850);
        wr(4'h8, 32'h99);
        wait_idle();
        rd(4'h0, v); chk("R11 flag", 128'(v), 128'h17848);
        chk("R11 write dropped", 128'(mem[8'h50]), 128'h77);
        wr(4'h8, 32'hAB);
        chk("R12 blocked by busy error", {127'd0, bus_req}, 128'd0);
        repeat (5) @(negedge clk);
        chk("R12 mem untouched", 128'(mem[8'h50]), 128'h77);
        wr(4'h0, 32'h48);
        rd(4'h0, v); chk("R11 clear", 128'(v), 128'h17840);

        // R11 touch in the cycle the bus answers
        lat = 2;
        wr(4'h4, 32'h60);
        wr(4'h8, 32'h11);
        begin
            int n = 0;
            #1;
            while (!bus_ack && n < 50) begin
                @(negedge clk);
                #1;
                n++;
            end
        end
        wr(4'h9, 32'h22);
        wait_idle();
        rd(4'h0, v); chk("R11 same-cycle flag", 128'(v), 128'h17848);
        rd(4'h9, v); chk("R11 same-cycle drop", 128'(v), 128'd0);
        chk("R11 same-cycle completion", 128'(mem[8'h60]), 128'h11);

        finish_run();
    end
endmodule